// File: doc/BRIEF.md
# Ultra DMA burst CRC checker

This block keeps the 16-bit CRC over every data word that crosses an Ultra DMA burst, in either direction. There is no bit clock on the link, so each accepted word advances the CRC in a single clock cycle. The update is combinational logic equal to sixteen serial steps of the generator x^16 + x^12 + x^5 + 1.

At the start of every burst the register is reloaded with the seed 4ABAh. When the burst ends, the host places its own CRC on the data bus and the acknowledge line is released. The control logic turns that release into a one-cycle `term_strobe`, with the host word on `host_crc`. The block then compares the host word with its own result and pulses `cmp_done`. On a mismatch it also sets a sticky `crc_err` flag, which the status logic reports as an interface CRC error for the command. The flag clears only when the next command starts.

Top module: `udma_crc_check`

## Requirements
- R1: After reset, `crc_out` is 4ABAh, and `cmp_done` and `crc_err` are 0.
- R2: A cycle with `burst_start` high loads the seed 4ABAh, and `crc_out` shows it after the next rising edge. If `word_valid` is also high in that cycle, that word is folded into the seed rather than into the old value.
- R3: Each cycle with `word_valid` high advances the CRC by one word, fed bit 15 first. The new value is the remainder of ((old CRC xor word) times x^16) divided by 0x11021. In a cycle with neither `word_valid` nor `burst_start`, `crc_out` holds its value.
- R4: A burst with no data words compares the host word against the seed 4ABAh.
- R5: `term_strobe` makes `cmp_done` high for exactly one cycle, one edge later. The comparison uses the `crc_out` value present in the `term_strobe` cycle.
- R6: If `host_crc` differs from the CRC when `term_strobe` is high, `crc_err` is set one edge later. A match leaves `crc_err` unchanged.
- R7: `crc_err` stays set until a cycle with `cmd_start` high, which clears it one edge later. If a mismatching compare falls in the same cycle as `cmd_start`, the flag is set.
- R8: `term_strobe` does not change `crc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Pulse when a new command begins; clears the error flag |
| burst_start | input | 1 | Pulse at the start of a burst; reloads the seed |
| word_valid | input | 1 | A data word crossed the link this cycle |
| word_data | input | 16 | The data word |
| term_strobe | input | 1 | Acknowledge released at burst end; host CRC is valid |
| host_crc | input | 16 | CRC word sent by the host |
| crc_out | output | 16 | Running CRC |
| cmp_done | output | 1 | One-cycle pulse after each compare |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The assertions assume every control input is a clean synchronous pulse. They also assume `host_crc` matters only in a `term_strobe` cycle, so the compare properties look at it only there.

The stimulus drives inputs on the falling edge only and keeps `term_strobe` apart from `word_valid` and `burst_start`, except in the deliberate overlap cases. The one overlap it targets on purpose is `cmd_start` together with a mismatch, to check which one wins. A sweep of single-word bursts across the 16-bit word space is compared against a polynomial long division done in the bench.

// File: rtl/udma_crc_check.sv
`timescale 1ns/1ps
module udma_crc_check #(
  parameter int DW = 16,
  parameter logic [DW-1:0] SEED = 16'h4ABA,
  parameter logic [DW-1:0] POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          burst_start,
  input  logic          word_valid,
  input  logic [DW-1:0] word_data,
  input  logic          term_strobe,
  input  logic [DW-1:0] host_crc,
  output logic [DW-1:0] crc_out,
  output logic          cmp_done,
  output logic          crc_err
);

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] c, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--)
      r = {r[DW-2:0], 1'b0} ^ ((r[DW-1] ^ d[i]) ? POLY : '0);
    return r;
  endfunction

  logic [DW-1:0] crc_q;
  logic [DW-1:0] base;
  logic [DW-1:0] crc_d;
  logic          mismatch;

  assign base     = burst_start ? SEED : crc_q;
  assign crc_d    = word_valid ? fold(base, word_data) : base;
  assign mismatch = term_strobe && (host_crc != crc_q);
  assign crc_out  = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= SEED;
      cmp_done <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      crc_q    <= crc_d;
      cmp_done <= term_strobe;
      crc_err  <= mismatch | (crc_err & ~cmd_start);
    end
  end

  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !word_valid) |=> (crc_q == SEED));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_start && !word_valid) |=> $stable(crc_q));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term_strobe |=> cmp_done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !term_strobe |=> !cmp_done);

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_strobe && (host_crc != crc_out)) |=> crc_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !cmd_start) |=> crc_err);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !term_strobe) |=> !crc_err);

  p_match_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_strobe && (host_crc == crc_out) && !crc_err && !cmd_start) |=> !crc_err);

endmodule

// File: tb/udma_crc_check_tb.sv
`timescale 1ns/1ps
module udma_crc_check_tb;
  logic clk = 0, rst_n = 0, cmd_start = 0, burst_start = 0, word_valid = 0, term_strobe = 0;
  logic [15:0] word_data = 0, host_crc = 0;
  logic [15:0] crc_out;
  logic cmp_done, crc_err;
  int tests = 0, fails = 0;
  logic [15:0] exp_crc = 16'h4ABA;
  logic exp_err = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #10 clk = ~clk;

  udma_crc_check u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .burst_start(burst_start),
    .word_valid(word_valid), .word_data(word_data), .term_strobe(term_strobe),
    .host_crc(host_crc), .crc_out(crc_out), .cmp_done(cmp_done), .crc_err(crc_err));

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] d);
    logic [31:0] v;
    v = {c ^ d, 16'h0};
    for (int b = 31; b >= 16; b--)
      if (v[b]) v = v ^ (32'h11021 << (b - 16));
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start_burst(input logic with_word, input logic [15:0] d);
    @(negedge clk);
    burst_start = 1; word_valid = with_word; word_data = d;
    @(negedge clk);
    burst_start = 0; word_valid = 0;
    exp_crc = with_word ? ref_step(16'h4ABA, d) : 16'h4ABA;
    chk("R2 seed", crc_out, exp_crc);
  endtask

  task automatic send_word(input logic [15:0] d);
    @(negedge clk);
    word_valid = 1; word_data = d;
    @(negedge clk);
    word_valid = 0;
    exp_crc = ref_step(exp_crc, d);
    chk("R3 word", crc_out, exp_crc);
  endtask

  task automatic finish_burst(input logic [15:0] h);
    @(negedge clk);
    term_strobe = 1; host_crc = h;
    @(negedge clk);
    term_strobe = 0;
    if (h != exp_crc) exp_err = 1;
    chk("R5 done", {15'd0, cmp_done}, 16'd1);
    chk("R6 err", {15'd0, crc_err}, {15'd0, exp_err});
    chk("R8 crc kept", crc_out, exp_crc);
    @(negedge clk);
    chk("R5 pulse", {15'd0, cmp_done}, 16'd0);
  endtask

  task automatic new_cmd();
    @(negedge clk);
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    exp_err = 0;
    chk("R7 clear", {15'd0, crc_err}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 crc", crc_out, 16'h4ABA);
    chk("R1 done", {15'd0, cmp_done}, 16'd0);
    chk("R1 err", {15'd0, crc_err}, 16'd0);
    rst_n = 1;

    start_burst(0, 16'h0);
    finish_burst(16'h4ABA);
    chk("R4 seed match", {15'd0, crc_err}, 16'd0);
    start_burst(0, 16'h0);
    finish_burst(16'h4ABB);
    chk("R4 seed miss", {15'd0, crc_err}, 16'd1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", {15'd0, crc_err}, 16'd1);
    start_burst(1, 16'h1234);
    finish_burst(exp_crc);
    chk("R7 sticky after match", {15'd0, crc_err}, 16'd1);
    new_cmd();

    start_burst(0, 16'h0);
    send_word(16'hBEEF);
    @(negedge clk);
    cmd_start = 1; term_strobe = 1; host_crc = ~exp_crc;
    @(negedge clk);
    cmd_start = 0; term_strobe = 0;
    exp_err = 1;
    chk("R7 set wins", {15'd0, crc_err}, 16'd1);
    new_cmd();

    for (int w = 0; w < 65536; w += 23) begin
      start_burst(w[0], 16'(w));
      if (!w[0]) send_word(16'(w));
      if ((w % 64) == 5) begin
        finish_burst(exp_crc ^ 16'h0001);
        new_cmd();
      end else begin
        finish_burst(exp_crc);
      end
    end

    for (int len = 1; len <= 12; len++) begin
      start_burst(0, 16'h0);
      for (int k = 0; k < len; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        send_word(lfsr);
        @(negedge clk);
        chk("R3 hold", crc_out, exp_crc);
      end
      finish_burst(len[0] ? exp_crc : exp_crc ^ 16'h8000);
      if (!len[0]) new_cmd();
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule